// File: doc/BRIEF.md
# Oscillator Buffer Ranking Calibration Sequencer

This block characterises a ring oscillator whose stages are built from many parallel tri-state inverting buffers. It drives one enable bit per buffer. After a start request it measures the oscillator with every buffer enabled, which gives the shortest period. It then measures once for each buffer with that buffer alone switched off. Each measurement counts oscillator rising edges during a window of a programmed number of reference-clock cycles. The measurement is repeated a power-of-two number of times and the mean count is kept. The effect of a buffer is the baseline mean minus its own mean: a smaller count means a longer period. A sequential bubble sort then orders the buffer indices from the largest effect to the smallest and leaves them in a ranking table that the rest of the chip reads through a combinational read port.

The ranking is normally computed once per design and reused. For that reason the table can also be loaded directly while the block is idle, and the measurement is then skipped. The edge counter runs on the oscillator clock. It returns its frozen count to the reference domain through a toggle handshake that is synchronised in both directions.

The controller states are IDLE, SETTLE, GATE, DRAIN, STORE and SORT:
- IDLE moves to SETTLE on start.
- SETTLE waits a fixed number of cycles after the enables change, then moves to GATE.
- GATE holds the counting window open for the programmed length, then moves to DRAIN.
- DRAIN waits for the count to return. It goes back to SETTLE for the next repetition, or on to STORE after the last repetition.
- STORE records the mean. It moves to SETTLE for the next configuration, or to SORT after the last buffer.
- SORT waits for the sorter to finish, then returns to IDLE and raises done.

The sorter has two states of its own, RK_IDLE and RK_SCAN.

Top module: `dcocal_top`

## Requirements
- R1: After reset, busy and done are 0, every bit of buf_en is 1, and table entry i holds index i.
- R2: A run first measures with all buffers enabled, then with buffer 0, 1, … NBUF-1 disabled in that order. buf_en bit i set to 0 disables buffer i, and at most one bit of buf_en is 0 at any time.
- R3: A measurement counts oscillator rising edges while the synchronised window is open. The window is open for win_len reference cycles. The count crosses to the reference domain only after the window closes and is held stable until the next window opens.
- R4: Each configuration is measured 2^rep_log2 times, and its mean is the sum of the counts shifted right by rep_log2.
- R5: A buffer's effect is the baseline mean minus its mean, or 0 if that is negative. After the sort, table entry 0 holds the buffer with the largest effect and later entries hold smaller effects. Equal effects are ordered by ascending buffer index.
- R6: busy is 1 from the cycle after an accepted start until the run completes. done rises only after the sort has finished and stays 1 until the next accepted start.
- R7: start is ignored while a run is in progress.
- R8: While idle, byp_wr writes byp_idx into table entry byp_addr. While busy, byp_wr has no effect.
- R9: rd_idx shows the table entry selected by rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| osc_clk | input | 1 | Oscillator output being measured |
| start | input | 1 | Pulse that starts a calibration run |
| win_len | input | WIN_W | Window length in reference cycles |
| rep_log2 | input | REPL_W | Log2 of the number of repetitions per configuration |
| busy | output | 1 | Run in progress |
| done | output | 1 | Ranking complete |
| buf_en | output | NBUF | Buffer enables, 1 = enabled |
| byp_wr | input | 1 | Direct table write strobe |
| byp_addr | input | IDX_W | Table entry to write |
| byp_idx | input | IDX_W | Buffer index to write |
| rd_addr | input | IDX_W | Table read address |
| rd_idx | output | IDX_W | Buffer index at that rank |

## Verification
The bench sweeps all 81 assignments of three periods over four buffers. This includes buffers with no effect and buffers with equal effects, so tie order and negative-delta clamping are exercised. A comparison with the wrong sense, or a missing tie rule, would put the wrong index at some rank. The bench measures how long each enable pattern is held across different window lengths and repetition counts. A window that is off by one cycle, or a repetition count that is wrong, changes those hold times away from their exact arithmetic ratios. It also repeats a run with a mid-run start and with writes to the table throughout. A design that restarts would take longer, and one that accepts the writes would corrupt entry 0.

// File: rtl/dcocal_pkg.sv
`timescale 1ps/1ps
package dcocal_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_GATE,
        SQ_DRAIN,
        SQ_STORE,
        SQ_SORT
    } seq_state_t;

    typedef enum logic [0:0] {
        RK_IDLE,
        RK_SCAN
    } rank_state_t;

endpackage

// File: rtl/dcocal_edge_cnt.sv
`timescale 1ps/1ps
module dcocal_edge_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate_ref,
    output logic [CNT_W-1:0] cnt_hold,
    output logic             ack_tgl
);

    logic g_s1, g_s2, g_d;

    // Window gate synchroniser, edge counter and return toggle, all in the oscillator domain
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            g_s1     <= 1'b0;
            g_s2     <= 1'b0;
            g_d      <= 1'b0;
            cnt_hold <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            g_s1 <= gate_ref;
            g_s2 <= g_s1;
            g_d  <= g_s2;
            if (g_s2 && !g_d)
                cnt_hold <= CNT_W'(1);
            else if (g_s2 && (cnt_hold != '1))
                cnt_hold <= cnt_hold + 1'b1;
            if (!g_s2 && g_d)
                ack_tgl <= ~ack_tgl;
        end
    end

    // R3: once the window is closed the count stays frozen for the reference domain to read
    assert_count_held_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !g_s2 |=> $stable(cnt_hold));

endmodule

// File: rtl/dcocal_rank.sv
`timescale 1ps/1ps
module dcocal_rank import dcocal_pkg::*; #(
    parameter int NBUF  = 8,
    parameter int KEY_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mwr,
    input  logic [IDX_W-1:0] maddr,
    input  logic [KEY_W-1:0] mkey,
    input  logic             bwr,
    input  logic [IDX_W-1:0] baddr,
    input  logic [IDX_W-1:0] bidx,
    input  logic             sort_go,
    output logic             sort_done,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [IDX_W-1:0] rd_idx
);

    rank_state_t      st_q, st_d;
    logic [KEY_W-1:0] key_q [NBUF];
    logic [IDX_W-1:0] idx_q [NBUF];
    logic [IDX_W-1:0] j_q, jn;
    logic             swp_q;
    logic             need_swap, last_pair;

    assign jn        = j_q + 1'b1;
    assign last_pair = (j_q == IDX_W'(NBUF - 2));
    // Larger effect moves up; on equal effect the lower buffer index moves up
    assign need_swap = (key_q[jn] > key_q[j_q]) ||
                       ((key_q[jn] == key_q[j_q]) && (idx_q[jn] < idx_q[j_q]));
    assign rd_idx    = idx_q[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RK_IDLE: if (sort_go) st_d = RK_SCAN;
            RK_SCAN: if (last_pair && !swp_q && !need_swap) st_d = RK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) begin
                key_q[i] <= '0;
                idx_q[i] <= IDX_W'(i);
            end
            j_q       <= '0;
            swp_q     <= 1'b0;
            sort_done <= 1'b0;
        end else begin
            sort_done <= 1'b0;
            unique case (st_q)
                RK_IDLE: begin
                    j_q   <= '0;
                    swp_q <= 1'b0;
                    if (!sort_go) begin
                        if (mwr) begin
                            key_q[maddr] <= mkey;
                            idx_q[maddr] <= maddr;
                        end
                        if (bwr)
                            idx_q[baddr] <= bidx;
                    end
                end
                RK_SCAN: begin
                    if (need_swap) begin
                        key_q[j_q] <= key_q[jn];
                        key_q[jn]  <= key_q[j_q];
                        idx_q[j_q] <= idx_q[jn];
                        idx_q[jn]  <= idx_q[j_q];
                    end
                    if (last_pair) begin
                        j_q   <= '0;
                        swp_q <= 1'b0;
                        if (!swp_q && !need_swap)
                            sort_done <= 1'b1;
                    end else begin
                        j_q   <= jn;
                        swp_q <= swp_q | need_swap;
                    end
                end
            endcase
        end
    end

    // R5: at completion every adjacent pair is in rank order
    for (genvar g = 0; g < NBUF - 1; g++) begin : g_order
        assert_ranked_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sort_done |-> ((key_q[g] > key_q[g+1]) ||
                           ((key_q[g] == key_q[g+1]) && (idx_q[g] < idx_q[g+1]))));
    end

endmodule

// File: rtl/dcocal_top.sv
`timescale 1ps/1ps
module dcocal_top import dcocal_pkg::*; #(
    parameter int NBUF       = 8,
    parameter int CNT_W      = 16,
    parameter int WIN_W      = 12,
    parameter int REPL_W     = 3,
    parameter int SETTLE_CYC = 4
) (
    input  logic                                      clk_ref,
    input  logic                                      rst_n,
    input  logic                                      osc_clk,
    input  logic                                      start,
    input  logic [WIN_W-1:0]                          win_len,
    input  logic [REPL_W-1:0]                         rep_log2,
    output logic                                      busy,
    output logic                                      done,
    output logic [NBUF-1:0]                           buf_en,
    input  logic                                      byp_wr,
    input  logic [((NBUF>1)?$clog2(NBUF):1)-1:0]      byp_addr,
    input  logic [((NBUF>1)?$clog2(NBUF):1)-1:0]      byp_idx,
    input  logic [((NBUF>1)?$clog2(NBUF):1)-1:0]      rd_addr,
    output logic [((NBUF>1)?$clog2(NBUF):1)-1:0]      rd_idx
);

    localparam int IDX_W  = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int CFG_W  = $clog2(NBUF + 1);
    localparam int REPC_W = 1 << REPL_W;
    localparam int ACC_W  = CNT_W + REPC_W;
    localparam int SET_W  = $clog2(SETTLE_CYC + 1);
    localparam int TMR_W  = (WIN_W > SET_W) ? WIN_W : SET_W;

    seq_state_t        state, state_d;
    logic [CFG_W-1:0]  cfg_q, cfg_d;
    logic [REPC_W-1:0] rep_q, rep_top;
    logic [ACC_W-1:0]  acc_q;
    logic [CNT_W-1:0]  base_q, mean, delta;
    logic [TMR_W-1:0]  tmr_q;
    logic [TMR_W:0]    tmr_inc;
    logic              gate_q, busy_q, done_q, sort_go_q, sort_done;
    logic [NBUF-1:0]   en_q, en_nx;
    logic [CNT_W-1:0]  cnt_hold;
    logic              ack_tgl, ack_s1, ack_s2, ack_s3, ack_evt;
    logic              win_end, settle_end, rep_last, cfg_last;
    logic              mwr, bwr;
    logic [IDX_W-1:0]  maddr;

    assign tmr_inc    = {1'b0, tmr_q} + 1'b1;
    assign win_end    = tmr_inc >= (TMR_W+1)'(win_len);
    assign settle_end = tmr_inc >= (TMR_W+1)'(SETTLE_CYC);
    assign rep_top    = (REPC_W'(1) << rep_log2) - 1'b1;
    assign rep_last   = (rep_q == rep_top);
    assign cfg_last   = (cfg_q == CFG_W'(NBUF));
    assign ack_evt    = ack_s2 ^ ack_s3;
    assign mean       = CNT_W'(acc_q >> rep_log2);
    assign delta      = (base_q > mean) ? (base_q - mean) : '0;

    assign busy   = busy_q;
    assign done   = done_q;
    assign buf_en = en_q;

    dcocal_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .gate_ref (gate_q),
        .cnt_hold (cnt_hold),
        .ack_tgl  (ack_tgl)
    );

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
            ack_s3 <= 1'b0;
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
            ack_s3 <= ack_s2;
        end
    end

    // State register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_d;
    end

    // Next state and next configuration (0 = baseline, k = buffer k-1 off)
    always_comb begin
        state_d = state;
        cfg_d   = cfg_q;
        unique case (state)
            SQ_IDLE:   if (start) begin
                           state_d = SQ_SETTLE;
                           cfg_d   = '0;
                       end
            SQ_SETTLE: if (settle_end) state_d = SQ_GATE;
            SQ_GATE:   if (win_end) state_d = SQ_DRAIN;
            SQ_DRAIN:  if (ack_evt) state_d = rep_last ? SQ_STORE : SQ_SETTLE;
            SQ_STORE:  if (cfg_last) state_d = SQ_SORT;
                       else begin
                           state_d = SQ_SETTLE;
                           cfg_d   = cfg_q + 1'b1;
                       end
            SQ_SORT:   if (sort_done) state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        en_nx = '1;
        if (state_d inside {SQ_SETTLE, SQ_GATE, SQ_DRAIN, SQ_STORE}) begin
            for (int i = 0; i < NBUF; i++)
                if (cfg_d == CFG_W'(i + 1)) en_nx[i] = 1'b0;
        end
    end

    // Outputs, registered from the next state
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            gate_q    <= 1'b0;
            en_q      <= '1;
            sort_go_q <= 1'b0;
        end else begin
            busy_q    <= (state_d != SQ_IDLE);
            gate_q    <= (state_d == SQ_GATE);
            en_q      <= en_nx;
            sort_go_q <= (state_d == SQ_SORT) && (state != SQ_SORT);
            if (state == SQ_IDLE && start)
                done_q <= 1'b0;
            else if (state == SQ_SORT && sort_done)
                done_q <= 1'b1;
        end
    end

    // Datapath: timer, repetitions, accumulation, baseline
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            rep_q  <= '0;
            acc_q  <= '0;
            base_q <= '0;
            tmr_q  <= '0;
        end else begin
            cfg_q <= cfg_d;
            if (state_d != state) tmr_q <= '0;
            else                  tmr_q <= tmr_inc[TMR_W-1:0];
            if (state == SQ_IDLE && start) begin
                rep_q <= '0;
                acc_q <= '0;
            end
            if (state == SQ_DRAIN && ack_evt) begin
                acc_q <= acc_q + ACC_W'(cnt_hold);
                rep_q <= rep_last ? '0 : rep_q + 1'b1;
            end
            if (state == SQ_STORE) begin
                acc_q <= '0;
                if (cfg_q == '0) base_q <= mean;
            end
        end
    end

    assign mwr   = (state == SQ_STORE) && (cfg_q != '0);
    assign maddr = IDX_W'(cfg_q - 1'b1);
    assign bwr   = byp_wr && (state == SQ_IDLE);

    dcocal_rank #(.NBUF(NBUF), .KEY_W(CNT_W), .IDX_W(IDX_W)) u_rank (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .mwr       (mwr),
        .maddr     (maddr),
        .mkey      (delta),
        .bwr       (bwr),
        .baddr     (byp_addr),
        .bidx      (byp_idx),
        .sort_go   (sort_go_q),
        .sort_done (sort_done),
        .rd_addr   (rd_addr),
        .rd_idx    (rd_idx)
    );

    // R2: never more than one buffer switched off
    assert_single_off_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $countones(~buf_en) <= 1);

    // R7: a start during a run never rewinds the configuration sequence
    assert_start_ignored_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state != SQ_IDLE && start) |=> (cfg_q >= $past(cfg_q)));

    // R6: done and busy are never high together
    assert_done_idle_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        done |-> !busy);

    // R4: the repetition counter never passes the programmed count
    assert_rep_bound_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state == SQ_DRAIN) |-> (rep_q <= rep_top));

endmodule

// File: tb/dcocal_top_test.sv
`timescale 1ps/1ps
module dcocal_top_test;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    win_len = 8'd32;
    logic [2:0]    rep_log2 = 3'd0;
    logic          busy, done;
    logic [N-1:0]  buf_en;
    logic          byp_wr = 1'b0;
    logic [IW-1:0] byp_addr = '0, byp_idx = '0, rd_addr = '0, rd_idx;

    int nchk = 0, nerr = 0;
    int per [N];
    int exp_rank [N];

    dcocal_top #(.NBUF(N), .CNT_W(16), .WIN_W(8), .REPL_W(3), .SETTLE_CYC(4)) uut (
        .clk_ref(clk), .rst_n(rst_n), .osc_clk(osc), .start(start),
        .win_len(win_len), .rep_log2(rep_log2), .busy(busy), .done(done),
        .buf_en(buf_en), .byp_wr(byp_wr), .byp_addr(byp_addr), .byp_idx(byp_idx),
        .rd_addr(rd_addr), .rd_idx(rd_idx));

    initial forever #10000 clk = ~clk;

    function automatic longint half_period();
        longint h = 1000;
        for (int i = 0; i < N; i++)
            if (!buf_en[i]) h = per[i] / 2;
        return h;
    endfunction

    // Oscillator model: edges sit on a fixed grid offset 3 ps, so counts are repeatable
    initial begin
        #3;
        forever begin
            longint h;
            longint r;
            h = half_period();
            r = (longint'($time) - 3) % h;
            #(h - r);
            osc = ~osc;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int zidx(input logic [N-1:0] e);
        int z = -1;
        for (int i = 0; i < N; i++) if (!e[i]) z = i;
        return z;
    endfunction

    task automatic compute_rank();
        bit used [N];
        for (int i = 0; i < N; i++) used[i] = 0;
        for (int p = 0; p < N; p++) begin
            int best = -1;
            for (int i = 0; i < N; i++)
                if (!used[i] && (best < 0 || per[i] > per[best])) best = i;
            used[best] = 1;
            exp_rank[p] = best;
        end
    endtask

    task automatic read_entry(input int a, output int v);
        rd_addr = IW'(a);
        #1;
        v = int'(rd_idx);
    endtask

    task automatic run_cal(input int win, input int rl, input bit extra, input bit spam,
                           output int len, output bit ord_ok, output int hold0);
        int ord [8];
        int nseen = 0;
        int multi = 0;
        logic [N-1:0] prev = '1;
        hold0 = 0;
        @(negedge clk);
        win_len = 8'(win); rep_log2 = 3'(rl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R6 busy after start", busy, 1);
        len = 1;
        while (!done && len < 30000) begin
            start = extra && (len == 100);
            if (spam) begin
                byp_wr = 1'b1; byp_addr = '0; byp_idx = IW'(exp_rank[N-1]);
            end
            if ($countones(~buf_en) > 1) multi++;
            if (buf_en != prev && buf_en != '1) begin
                if (nseen < 8) ord[nseen] = zidx(buf_en);
                nseen++;
            end
            if (buf_en == 4'b1110) hold0++;
            prev = buf_en;
            @(negedge clk);
            len++;
        end
        start = 1'b0;
        byp_wr = 1'b0;
        ord_ok = (nseen == N) && (multi == 0);
        for (int k = 0; k < N && k < nseen; k++) if (ord[k] != k) ord_ok = 0;
        chk(done === 1'b1 && busy === 1'b0, "R6 done at end", done, 1);
    endtask

    task automatic check_table(input string tag);
        for (int k = 0; k < N; k++) begin
            int v;
            read_entry(k, v);
            chk(v == exp_rank[k], tag, v, exp_rank[k]);
        end
    endtask

    initial begin
        int len, la, lb, h1, h2, h3, v;
        bit ok;
        int vals [3] = '{2000, 2500, 4000};
        for (int i = 0; i < N; i++) per[i] = 2000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(buf_en === 4'b1111, "R1 buf_en", buf_en, 15);
        for (int k = 0; k < N; k++) begin
            read_entry(k, v);
            chk(v == k, "R1 R9 reset table", v, k);
        end
        // R8 bypass load while idle, read back through R9
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            byp_wr = 1'b1; byp_addr = IW'(k); byp_idx = IW'(N - 1 - k);
        end
        @(negedge clk);
        byp_wr = 1'b0;
        for (int k = 0; k < N; k++) begin
            read_entry(k, v);
            chk(v == N - 1 - k, "R8 R9 bypass load", v, N - 1 - k);
        end
        // R5 R2 sweep of all period assignments
        for (int s = 0; s < 81; s++) begin
            int d = s;
            for (int i = 0; i < N; i++) begin
                per[i] = vals[d % 3];
                d = d / 3;
            end
            compute_rank();
            run_cal((s % 2) ? 32 : 48, s % 3, 1'b0, 1'b0, len, ok, h1);
            chk(ok, "R2 disable order", ok, 1);
            check_table("R5 ranking");
        end
        // R6 done persists while idle
        repeat (5) @(negedge clk);
        chk(done === 1'b1, "R6 done held", done, 1);
        // R3 and R4 through the hold time of buffer 0's configuration
        per[0] = 4000; per[1] = 2500; per[2] = 2000; per[3] = 2500;
        compute_rank();
        run_cal(32, 0, 1'b0, 1'b0, la, ok, h1);
        run_cal(48, 0, 1'b0, 1'b0, len, ok, h2);
        chk(h2 - h1 == 16, "R3 window length", h2 - h1, 16);
        run_cal(32, 2, 1'b0, 1'b0, len, ok, h3);
        chk(h3 - 1 == 4 * (h1 - 1), "R4 repetitions", h3 - 1, 4 * (h1 - 1));
        check_table("R5 ranking after repeats");
        // R7 start ignored mid-run, R8 writes ignored while busy
        run_cal(32, 1, 1'b0, 1'b0, la, ok, h1);
        run_cal(32, 1, 1'b1, 1'b1, lb, ok, h1);
        chk(lb == la, "R7 run length", lb, la);
        read_entry(0, v);
        chk(v == exp_rank[0], "R8 busy write ignored", v, exp_rank[0]);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", done, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule